// File: doc/BRIEF.md
# Accumulator ALU with Registered Condition Codes

This block is the arithmetic and logic datapath of a small accumulator machine. It takes the accumulator byte, the index low byte and a memory operand, applies one of sixteen operations selected by a 4-bit code, and presents the result combinationally. The carry, overflow, negative and zero flags are held in a register inside the block. A registered flag is updated on the next rising clock edge only when the operation's class defines that flag.

The write-enable input chooses between two uses. A normal operation returns the computed byte. A flags-only operation returns the accumulator and index bytes unchanged while the flags are still updated. The compare code always behaves as flags-only. Carry and half-carry come in as plain inputs, so the surrounding core decides where they are taken from. Operand fetch, addressing and writeback stay outside the block.

Top module: `acc_alu8`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry_in) give `res_lo` = A+M(+carry_in) mod 256. C is the carry out of bit 7. V is 1 exactly when A[7] equals M[7] and the result's bit 7 differs from them.
- R2: Codes 2 (subtract) and 3 (subtract with borrow: A−M, then one more when carry_in is 1) give `res_lo` = A−M(−carry_in) mod 256. C is 1 when M plus the borrow-in exceeds A as unsigned values. V is 1 exactly when A[7]≠M[7] and the result's bit 7 differs from A[7].
- R3: Code 4 (compare) sets all four flags as code 2 does, and always drives `res_lo` = acc_in. With wr_en=0, any code drives `res_lo` = acc_in and `res_hi` = idx_in while the flags still update.
- R4: Shifts act on A. Code 5 shifts left with 0 into bit 0, C = old bit 7. Code 6 shifts right with 0 into bit 7, C = old bit 0. Code 7 rotates left through carry_in, C = old bit 7. Code 8 rotates right through carry_in, C = old bit 0. For all four, V = N xor C of the new flags.
- R5: Codes 9 (AND), 10 (OR) and 11 (XOR) combine A with M. Z is set for a zero result, N = bit 7, V = 0, and C keeps its previous value.
- R6: Code 12 (clear) gives 0x00 with Z=1, N=0, V=0, and C keeps its previous value.
- R7: Code 13 exchanges the two nibbles of A and leaves all flags unchanged.
- R8: Code 14 multiplies X by A unsigned. `res_hi` is the product's upper byte and `res_lo` its lower byte. All flags are left unchanged.
- R9: Code 15 (decimal adjust) adds 0x06 when half_in=1 or A[3:0]>9, and adds 0x60 when carry_in=1 or A>0x99. C is 1 exactly in the second case. N and Z follow the result, and V = old A[7] xor result bit 7.
- R10: Flags change only on a rising edge with upd=1. A synchronous reset clears all four to 0. Flags are visible one edge after the operation is presented.
- R11: For every code except a written multiply, `res_hi` equals idx_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| upd | input | 1 | Commit the new flags on this edge |
| op_sel | input | 4 | Operation code 0..15 |
| wr_en | input | 1 | 1: normal result, 0: flags-only |
| acc_in | input | 8 | Accumulator operand A |
| idx_in | input | 8 | Index low byte X |
| mem_in | input | 8 | Memory operand M |
| carry_in | input | 1 | Incoming carry or borrow |
| half_in | input | 1 | Incoming half-carry for decimal adjust |
| res_lo | output | 8 | Result byte (accumulator destination) |
| res_hi | output | 8 | Upper byte (index destination) |
| flag_c | output | 1 | Registered carry/borrow |
| flag_v | output | 1 | Registered overflow |
| flag_n | output | 1 | Registered negative |
| flag_z | output | 1 | Registered zero |

## Verification
The only state in the block is the four flag bits. A wrong update rule or enable mask shows up one clock edge after the offending operation, when the flag outputs are compared. A flag that should have been held but was overwritten also stays wrong at later checks, until an operation that defines that flag corrects it. Errors in the result path appear at once on `res_lo`/`res_hi` in the same cycle. For that reason, every vector compares both the combinational bytes and the flags registered after the edge.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int PW = 2 * DW;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0, OP_ADC  = 4'h1, OP_SUB  = 4'h2, OP_SBC  = 4'h3,
        OP_CMP  = 4'h4, OP_ASL  = 4'h5, OP_LSR  = 4'h6, OP_ROL  = 4'h7,
        OP_ROR  = 4'h8, OP_AND  = 4'h9, OP_ORA  = 4'hA, OP_EOR  = 4'hB,
        OP_CLR  = 4'hC, OP_SWAP = 4'hD, OP_MUL  = 4'hE, OP_DAA  = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } ccr_t;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        ccr_t          f;
        ccr_t          we;
    } unit_out_t;

    function automatic logic top_bit(input logic [DW-1:0] v);
        return v[DW-1];
    endfunction

    function automatic logic all_zero(input logic [DW-1:0] v);
        return (v == '0);
    endfunction

    function automatic ccr_t mask_of(input logic c, input logic vnz);
        ccr_t m;
        m.c = c;
        m.v = vnz;
        m.n = vnz;
        m.z = vnz;
        return m;
    endfunction
endpackage

// File: rtl/acc_alu8_arith.sv
module acc_alu8_arith
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output unit_out_t     o
);
    logic          is_sub;
    logic          c0;
    logic [DW-1:0] b;
    logic [DW-1:0] s;
    logic [DW:0]   cy;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        b      = is_sub ? ~m : m;
        case (op)
            OP_ADC:  c0 = cin;
            OP_SUB:  c0 = 1'b1;
            OP_CMP:  c0 = 1'b1;
            OP_SBC:  c0 = ~cin;
            default: c0 = 1'b0;
        endcase
    end

    assign cy[0] = c0;

    for (genvar i = 0; i < DW; i++) begin : g_rip
        assign s[i]    = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end

    always_comb begin
        o      = '0;
        o.lo   = s;
        o.we   = mask_of(1'b1, 1'b1);
        o.f.n  = top_bit(s);
        o.f.z  = all_zero(s);
        if (is_sub) begin
            o.f.c = ~cy[DW];
            o.f.v = (top_bit(a) & ~top_bit(m) & ~top_bit(s)) |
                    (~top_bit(a) & top_bit(m) & top_bit(s));
        end else begin
            o.f.c = cy[DW];
            o.f.v = (top_bit(a) & top_bit(m) & ~top_bit(s)) |
                    (~top_bit(a) & ~top_bit(m) & top_bit(s));
        end
    end
endmodule

// File: rtl/acc_alu8_shift.sv
module acc_alu8_shift
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output unit_out_t     o
);
    logic [DW-1:0] r;
    logic          out_bit;

    always_comb begin
        case (op)
            OP_LSR: begin
                r       = {1'b0, a[DW-1:1]};
                out_bit = a[0];
            end
            OP_ROL: begin
                r       = {a[DW-2:0], cin};
                out_bit = a[DW-1];
            end
            OP_ROR: begin
                r       = {cin, a[DW-1:1]};
                out_bit = a[0];
            end
            default: begin
                r       = {a[DW-2:0], 1'b0};
                out_bit = a[DW-1];
            end
        endcase
        o     = '0;
        o.lo  = r;
        o.we  = mask_of(1'b1, 1'b1);
        o.f.c = out_bit;
        o.f.n = top_bit(r);
        o.f.z = all_zero(r);
        o.f.v = top_bit(r) ^ out_bit;
    end
endmodule

// File: rtl/acc_alu8_misc.sv
module acc_alu8_misc
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          hin,
    output unit_out_t     o
);
    localparam logic [NW-1:0] DEC_LIM = NW'(9);
    localparam logic [DW-1:0] BYTE_LIM = {DEC_LIM, DEC_LIM};
    localparam logic [NW-1:0] ADJ_NIB = NW'(6);

    logic [PW-1:0] prod;
    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] adj;
    logic [DW-1:0] dec_r;

    always_comb begin
        prod   = PW'(a) * PW'(x);
        lo_fix = hin || (a[NW-1:0] > DEC_LIM);
        hi_fix = cin || (a > BYTE_LIM);
        adj    = {(hi_fix ? ADJ_NIB : '0), (lo_fix ? ADJ_NIB : '0)};
        dec_r  = a + adj;
    end

    always_comb begin
        o = '0;
        case (op)
            OP_AND:  begin o.lo = a & m; o.we = mask_of(1'b0, 1'b1); end
            OP_ORA:  begin o.lo = a | m; o.we = mask_of(1'b0, 1'b1); end
            OP_EOR:  begin o.lo = a ^ m; o.we = mask_of(1'b0, 1'b1); end
            OP_CLR:  begin o.lo = '0;    o.we = mask_of(1'b0, 1'b1); end
            OP_SWAP: begin o.lo = {a[NW-1:0], a[DW-1:NW]}; end
            OP_MUL:  begin o.lo = prod[DW-1:0]; o.hi = prod[PW-1:DW]; end
            default: begin
                o.lo  = dec_r;
                o.we  = mask_of(1'b1, 1'b1);
                o.f.c = hi_fix;
            end
        endcase
        o.f.n = top_bit(o.lo);
        o.f.z = all_zero(o.lo);
        if (op == OP_DAA) o.f.v = top_bit(a) ^ top_bit(dec_r);
        else              o.f.v = 1'b0;
    end
endmodule

// File: rtl/acc_alu8_ccr.sv
module acc_alu8_ccr
    import acc_alu8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  ccr_t nxt,
    input  ccr_t we,
    output ccr_t cur
);
    localparam int NF = $bits(ccr_t);

    logic [NF-1:0] nxt_v;
    logic [NF-1:0] we_v;
    logic [NF-1:0] cur_v;

    assign nxt_v = nxt;
    assign we_v  = we;
    assign cur   = cur_v;

    for (genvar i = 0; i < NF; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                  cur_v[i] <= 1'b0;
            else if (upd && we_v[i])  cur_v[i] <= nxt_v[i];
        end
    end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [3:0]    op_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] idx_in,
    input  logic [DW-1:0] mem_in,
    input  logic          carry_in,
    input  logic          half_in,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_n,
    output logic          flag_z
);
    alu_op_e   op_e;
    unit_out_t ar_o;
    unit_out_t sh_o;
    unit_out_t mi_o;
    unit_out_t sel;
    ccr_t      cur;

    assign op_e = alu_op_e'(op_sel);

    acc_alu8_arith u_arith (
        .op (op_e), .a (acc_in), .m (mem_in), .cin (carry_in), .o (ar_o)
    );

    acc_alu8_shift u_shift (
        .op (op_e), .a (acc_in), .cin (carry_in), .o (sh_o)
    );

    acc_alu8_misc u_misc (
        .op (op_e), .a (acc_in), .x (idx_in), .m (mem_in),
        .cin (carry_in), .hin (half_in), .o (mi_o)
    );

    always_comb begin
        case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: sel = ar_o;
            OP_ASL, OP_LSR, OP_ROL, OP_ROR:         sel = sh_o;
            default:                                sel = mi_o;
        endcase
    end

    always_comb begin
        if (!wr_en || op_e == OP_CMP) begin
            res_lo = acc_in;
            res_hi = idx_in;
        end else begin
            res_lo = sel.lo;
            res_hi = (op_e == OP_MUL) ? sel.hi : idx_in;
        end
    end

    acc_alu8_ccr u_ccr (
        .clk (clk), .rst (rst), .upd (upd),
        .nxt (sel.f), .we (sel.we), .cur (cur)
    );

    assign flag_c = cur.c;
    assign flag_v = cur.v;
    assign flag_n = cur.n;
    assign flag_z = cur.z;
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk
    import acc_alu8_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          upd,
    input logic [3:0]    op_sel,
    input logic          wr_en,
    input logic [DW-1:0] acc_in,
    input logic [DW-1:0] idx_in,
    input logic [DW-1:0] res_lo,
    input logic [DW-1:0] res_hi,
    input logic          flag_c,
    input logic          flag_v,
    input logic          flag_n,
    input logic          flag_z
);
    logic is_shift, is_logic, is_arith;
    assign is_shift = (op_sel >= OP_ASL) && (op_sel <= OP_ROR);
    assign is_logic = (op_sel >= OP_AND) && (op_sel <= OP_EOR);
    assign is_arith = (op_sel <= OP_SBC);

    AST_ZN_FOLLOW_RESULT: assert property (@(posedge clk) disable iff (rst)
        (upd && wr_en && is_arith) |=> (flag_z == ($past(res_lo) == '0)) && (flag_n == $past(res_lo[DW-1]))); // R1

    AST_CMP_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_CMP) |-> (res_lo == acc_in)); // R3

    AST_SHIFT_V_RULE: assert property (@(posedge clk) disable iff (rst)
        (upd && is_shift) |=> (flag_v == (flag_n ^ flag_c))); // R4

    AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (upd && is_logic) |=> (!flag_v && $stable(flag_c))); // R5

    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (upd && op_sel == OP_CLR) |=> (flag_z && !flag_n && !flag_v)); // R6

    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (upd && op_sel == OP_SWAP) |=> $stable({flag_c, flag_v, flag_n, flag_z})); // R7

    AST_MUL_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (upd && op_sel == OP_MUL) |=> $stable({flag_c, flag_v, flag_n, flag_z})); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable({flag_c, flag_v, flag_n, flag_z})); // R10

    AST_HI_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_sel != OP_MUL || !wr_en) |-> (res_hi == idx_in)); // R11
endmodule

bind acc_alu8 acc_alu8_chk u_chk (
    .clk (clk), .rst (rst), .upd (upd), .op_sel (op_sel), .wr_en (wr_en),
    .acc_in (acc_in), .idx_in (idx_in), .res_lo (res_lo), .res_hi (res_hi),
    .flag_c (flag_c), .flag_v (flag_v), .flag_n (flag_n), .flag_z (flag_z)
);

// File: tb/acc_alu8_test.sv
`timescale 1ns/1ps
module acc_alu8_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd = 1'b0;
    logic [3:0] op_sel = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] acc_in = 8'h00, idx_in = 8'h00, mem_in = 8'h00;
    logic       carry_in = 1'b0, half_in = 1'b0;
    logic [7:0] res_lo, res_hi;
    logic       flag_c, flag_v, flag_n, flag_z;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [3:0] exp_f = 4'h0;

    always #5 clk = ~clk;

    acc_alu8 uut (
        .clk (clk), .rst (rst), .upd (upd), .op_sel (op_sel), .wr_en (wr_en),
        .acc_in (acc_in), .idx_in (idx_in), .mem_in (mem_in),
        .carry_in (carry_in), .half_in (half_in),
        .res_lo (res_lo), .res_hi (res_hi),
        .flag_c (flag_c), .flag_v (flag_v), .flag_n (flag_n), .flag_z (flag_z)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:          return "R1";
            4'd2, 4'd3:          return "R2";
            4'd4:                return "R3";
            4'd5, 4'd6, 4'd7, 4'd8: return "R4";
            4'd9, 4'd10, 4'd11:  return "R5";
            4'd12:               return "R6";
            4'd13:               return "R7";
            4'd14:               return "R8";
            default:             return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] m, input logic c, input logic h,
                         input logic wr, input logic u);
        int          s;
        int          bi;
        logic [7:0]  r;
        logic [15:0] p;
        logic        fc, fv;
        logic [3:0]  msk, nf;
        logic [7:0]  elo, ehi;
        @(negedge clk);
        op_sel = op; acc_in = a; idx_in = x; mem_in = m;
        carry_in = c; half_in = h; wr_en = wr; upd = u;
        #1;
        r = 8'h00; p = 16'h0; fc = 1'b0; fv = 1'b0; msk = 4'hF;
        case (op)
            4'd0, 4'd1: begin
                s  = int'(a) + int'(m) + ((op == 4'd1) ? int'(c) : 0);
                r  = 8'(s);
                fc = (s > 255);
                fv = (a[7] == m[7]) && (r[7] != a[7]);
            end
            4'd2, 4'd3, 4'd4: begin
                bi = (op == 4'd3) ? int'(c) : 0;
                s  = int'(a) - int'(m) - bi;
                r  = 8'(s);
                fc = (int'(m) + bi) > int'(a);
                fv = (a[7] != m[7]) && (r[7] != a[7]);
            end
            4'd5: begin r = {a[6:0], 1'b0}; fc = a[7]; fv = r[7] ^ fc; end
            4'd6: begin r = {1'b0, a[7:1]}; fc = a[0]; fv = r[7] ^ fc; end
            4'd7: begin r = {a[6:0], c};    fc = a[7]; fv = r[7] ^ fc; end
            4'd8: begin r = {c, a[7:1]};    fc = a[0]; fv = r[7] ^ fc; end
            4'd9:  begin r = a & m; msk = 4'b0111; end
            4'd10: begin r = a | m; msk = 4'b0111; end
            4'd11: begin r = a ^ m; msk = 4'b0111; end
            4'd12: begin r = 8'h00; msk = 4'b0111; end
            4'd13: begin r = {a[3:0], a[7:4]}; msk = 4'b0000; end
            4'd14: begin p = 16'(int'(a) * int'(x)); r = p[7:0]; msk = 4'b0000; end
            default: begin
                s = int'(a);
                if (h || (int'(a) % 16) > 9) s = s + 6;
                if (c || int'(a) > 153) begin s = s + 96; fc = 1'b1; end
                r  = 8'(s);
                fv = a[7] ^ r[7];
            end
        endcase
        nf = {fc, fv, r[7], (r == 8'h00)};
        if (!wr || op == 4'd4) begin
            elo = a; ehi = x;
        end else begin
            elo = r; ehi = (op == 4'd14) ? p[15:8] : x;
        end
        chk((!wr || op == 4'd4) ? "R3" : tag_of(op), "res_lo", res_lo, elo);
        chk((wr && op == 4'd14) ? "R8" : "R11", "res_hi", res_hi, ehi);
        if (u) exp_f = (msk & nf) | (~msk & exp_f);
        @(posedge clk);
        #1;
        chk(u ? tag_of(op) : "R10", "flags CVNZ",
            {4'h0, flag_c, flag_v, flag_n, flag_z}, {4'h0, exp_f});
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [7:0] corner [4];
        corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;
        void'($urandom(32'h00C0FFEE));

        repeat (2) @(posedge clk);
        #1;
        chk("R10", "reset flags", {4'h0, flag_c, flag_v, flag_n, flag_z}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        exp_f = 4'h0;

        // directed: known worked cases
        apply(4'd0, 8'h7F, 8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1); // R1 overflow into sign
        apply(4'd3, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1); // R2 borrow-in only
        apply(4'd4, 8'h10, 8'h22, 8'h10, 1'b0, 1'b0, 1'b1, 1'b1); // R3 equal compare
        apply(4'd14, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1); // R8 max product
        apply(4'd15, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1); // R9 both adjusts
        apply(4'd12, 8'h55, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1); // R6
        apply(4'd13, 8'hA5, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1); // R7

        // boundary operand sweep for every code
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply(4'(op), corner[i], corner[j], corner[j],
                              1'(c), 1'(c), 1'b1, 1'b1);
                    end
                end
            end
        end

        // constrained random with idle and flags-only cycles
        for (int k = 0; k < 4000; k++) begin
            apply(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom),
                  ($urandom % 4) != 0, ($urandom % 5) != 0);
        end

        // mid-run reset
        @(negedge clk);
        rst = 1'b1; upd = 1'b0;
        @(posedge clk);
        #1;
        chk("R10", "reset flags mid-run", {4'h0, flag_c, flag_v, flag_n, flag_z}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        exp_f = 4'h0;
        apply(4'd2, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1); // R2 wrap to 0xFF

        done = 1;
        summary();
        $finish;
    end
endmodule